// File: doc/BRIEF.md
# Streaming Block Program Sequencer

This block is the write state machine of a simplified flash memory model, for a fast factory-programming mode. The host opens a session with a setup command that names one block. It then streams data words over a valid/ready channel and sends no per-word addresses. The sequencer first reads the target word to confirm that it is still erased. It then fires one program strobe to the array and waits a fixed pulse time. After that it moves the word address forward by one. When the program phase ends, the sequencer re-reads every word it wrote in the session and compares each against a private copy of the written data. It then passes through a one-cycle exit phase and returns to idle.

A status word reports ready/busy, an active session, and three sticky error flags: program, verify and lock. It also holds the address of the first word that failed verify. The array port is synchronous. A read returns data one cycle after `arr_rd_en`. A program strobe can only clear bits, and an erased word reads as all ones.

Back-pressure rules: a beat transfers on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is high only while the sequencer waits for data in the program phase. The host must hold `wr_valid` and `wr_data` steady until the beat is taken. Commands on `cmd_valid`/`cmd_op` are one-cycle strobes and are never stalled.

Top module: `stream_prog_seq`

## Requirements
- R1: A setup command (op 1, block index on `cmd_blk`) in idle opens a session on an unlocked block. The session runs setup, program, verify and exit in that order and then returns to idle. `stat_active` is high from the cycle after setup until the return to idle, and the verify phase issues one array read per programmed word.
- R2: The n-th accepted word of a session (counting from 0) is programmed at array address {block index, n}. The block index forms the upper bits and n the lower log2(BLK_WORDS) bits.
- R3: After a beat is accepted, `wr_ready` stays low and `stat_busy` stays high for exactly PULSE_CYC+2 cycles: one pre-read, one check and strobe cycle, and PULSE_CYC pulse cycles. Exactly one `arr_prog` strobe is issued per word.
- R4: After BLK_WORDS words the program phase ends on its own. No further beat is accepted and no address runs past the block.
- R5: An end command (op 3) ends the program phase. If a beat transfers in the same cycle as the end command, that beat is programmed first and the phase then ends.
- R6: In verify, a word whose array content differs from the written data sets the verify-error flag. `fail_addr` records the array address of the first such word seen while the flag was clear.
- R7: If the target word does not read all ones before programming, the program-error flag is set and that word gets no strobe, but the address still advances.
- R8: A setup on a block whose `lock_map` bit is 1 sets the lock-error flag, programs nothing and returns to idle.
- R9: A suspend command (op 4) is ignored: the session completes exactly as it would without it.
- R10: `part_rd_grant` follows `part_rd_req` in idle and is 0 while a session is active.
- R11: The error flags stay set across later sessions until a clear command (op 2) is given in idle, which clears all three.
- R12: After reset all status outputs and `wr_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code: 1 setup, 2 clear, 3 end, 4 suspend |
| cmd_blk | input | BAW | Block index for setup |
| lock_map | input | NBLK | Lock bit per block |
| wr_valid | input | 1 | Data beat valid |
| wr_ready | output | 1 | Sequencer can take a beat |
| wr_data | input | DW | Data beat |
| part_rd_req | input | 1 | Read request from another partition |
| part_rd_grant | output | 1 | Partition read granted |
| arr_prog | output | 1 | One-cycle program strobe |
| arr_rd_en | output | 1 | Array read enable |
| arr_addr | output | AW | Array word address |
| arr_wdata | output | DW | Data to program |
| arr_rdata | input | DW | Read data, one cycle after `arr_rd_en` |
| stat_busy | output | 1 | Sequencer busy, not waiting for data |
| stat_active | output | 1 | Session in progress |
| stat_prog_err | output | 1 | Sticky program error |
| stat_verify_err | output | 1 | Sticky verify error |
| stat_lock_err | output | 1 | Sticky lock error |
| fail_addr | output | AW | First verify-failure address |

## Verification
The end command and a data beat can transfer in the same cycle. The bench provokes this by raising `wr_valid` and the end command together at a negative edge while `wr_ready` is high. It then judges the result from the program-strobe count and the array model: the simultaneous beat must land at the next address and no later word may be touched. A suspend command inserted between beats is judged the same way, by requiring a result identical to an undisturbed session.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_PROG, ST_PRERD, ST_PRCHK,
    ST_PULSE, ST_VRD, ST_VCHK, ST_EXIT
  } sps_state_e;

  localparam logic [2:0] OP_SETUP   = 3'd1;
  localparam logic [2:0] OP_CLEAR   = 3'd2;
  localparam logic [2:0] OP_END     = 3'd3;
  localparam logic [2:0] OP_SUSPEND = 3'd4;
endpackage

// File: rtl/sps_pulse_timer.sv
module sps_pulse_timer #(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic running,
  output logic done
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (start)         cnt <= CW'(PULSE_CYC);
    else if (cnt != '0)     cnt <= cnt - CW'(1);
  end

  assign running = (cnt != '0);
  assign done    = (cnt == CW'(1));

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !running); // R3
endmodule

// File: rtl/sps_wbuf.sv
module sps_wbuf #(
  parameter int DEPTH = 64,
  parameter int DW    = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sps_status.sv
module sps_status #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_prog,
  input  logic          set_ver,
  input  logic          set_lock,
  input  logic          clr,
  input  logic [AW-1:0] ver_addr,
  output logic          prog_err,
  output logic          ver_err,
  output logic          lock_err,
  output logic [AW-1:0] fail_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_err  <= 1'b0;
      ver_err   <= 1'b0;
      lock_err  <= 1'b0;
      fail_addr <= '0;
    end else if (clr) begin
      prog_err  <= 1'b0;
      ver_err   <= 1'b0;
      lock_err  <= 1'b0;
      fail_addr <= '0;
    end else begin
      if (set_prog) prog_err <= 1'b1;
      if (set_lock) lock_err <= 1'b1;
      if (set_ver) begin
        ver_err <= 1'b1;
        if (!ver_err) fail_addr <= ver_addr;
      end
    end
  end

  AST_VERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ver_err && !clr) |=> ver_err); // R11
  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_err && !clr) |=> prog_err); // R11
  AST_FAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ver_err && !clr) |=> $stable(fail_addr)); // R6
endmodule

// File: rtl/stream_prog_seq.sv
module stream_prog_seq
  import sps_pkg::*;
#(
  parameter int NBLK      = 16,
  parameter int BLK_WORDS = 64,
  parameter int DW        = 16,
  parameter int PULSE_CYC = 4,
  localparam int BAW      = $clog2(NBLK),
  localparam int WAW      = $clog2(BLK_WORDS),
  localparam int AW       = BAW + WAW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [2:0]     cmd_op,
  input  logic [BAW-1:0] cmd_blk,
  input  logic [NBLK-1:0] lock_map,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [DW-1:0]  wr_data,
  input  logic           part_rd_req,
  output logic           part_rd_grant,
  output logic           arr_prog,
  output logic           arr_rd_en,
  output logic [AW-1:0]  arr_addr,
  output logic [DW-1:0]  arr_wdata,
  input  logic [DW-1:0]  arr_rdata,
  output logic           stat_busy,
  output logic           stat_active,
  output logic           stat_prog_err,
  output logic           stat_verify_err,
  output logic           stat_lock_err,
  output logic [AW-1:0]  fail_addr
);
  localparam int CW = WAW + 1;
  localparam logic [CW-1:0] FULL = CW'(BLK_WORDS);

  sps_state_e     state, state_n;
  logic [BAW-1:0] blk_q;
  logic [CW-1:0]  wcnt;
  logic [WAW-1:0] vidx;
  logic [DW-1:0]  dat_q;
  logic           end_pend;

  logic accept, end_cmd, setup_cmd, clr_cmd;
  logic erased, pulse_start, pulse_run, pulse_done;
  logic advance, last_v, mism;
  logic [CW-1:0]  wcnt_n;
  logic [DW-1:0]  buf_rd;
  logic set_prog, set_ver, set_lock;

  assign accept    = wr_valid && wr_ready;
  assign end_cmd   = cmd_valid && (cmd_op == OP_END);
  assign setup_cmd = cmd_valid && (cmd_op == OP_SETUP) && (state == ST_IDLE);
  assign clr_cmd   = cmd_valid && (cmd_op == OP_CLEAR) && (state == ST_IDLE);
  assign erased    = (arr_rdata == {DW{1'b1}});
  assign wcnt_n    = wcnt + CW'(1);
  assign last_v    = ({1'b0, vidx} + CW'(1)) == wcnt;
  assign mism      = (arr_rdata != buf_rd);

  // advance fires when a word's handling is complete (pulse end or skipped)
  assign advance = (state == ST_PULSE && pulse_done) ||
                   (state == ST_PRCHK && !erased);

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:  if (setup_cmd) state_n = ST_SETUP;
      ST_SETUP: state_n = lock_map[blk_q] ? ST_IDLE : ST_PROG;
      ST_PROG: begin
        if (accept)       state_n = ST_PRERD;
        else if (end_cmd) state_n = (wcnt == '0) ? ST_EXIT : ST_VRD;
      end
      ST_PRERD: state_n = ST_PRCHK;
      ST_PRCHK: begin
        if (erased) state_n = ST_PULSE;
        else        state_n = (end_pend || wcnt_n == FULL) ? ST_VRD : ST_PROG;
      end
      ST_PULSE: if (pulse_done)
                  state_n = (end_pend || wcnt_n == FULL) ? ST_VRD : ST_PROG;
      ST_VRD:   state_n = ST_VCHK;
      ST_VCHK:  state_n = last_v ? ST_EXIT : ST_VRD;
      ST_EXIT:  state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      blk_q    <= '0;
      wcnt     <= '0;
      vidx     <= '0;
      dat_q    <= '0;
      end_pend <= 1'b0;
    end else begin
      state <= state_n;
      if (setup_cmd) begin
        blk_q    <= cmd_blk;
        wcnt     <= '0;
        vidx     <= '0;
        end_pend <= 1'b0;
      end else begin
        if (end_cmd && stat_active && state != ST_PROG) end_pend <= 1'b1;
        if (end_cmd && accept)                          end_pend <= 1'b1;
        if (accept)  dat_q <= wr_data;
        if (advance) wcnt  <= wcnt_n;
        if (state == ST_VCHK) vidx <= vidx + WAW'(1);
      end
    end
  end

  sps_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(pulse_start),
    .running(pulse_run), .done(pulse_done)
  );

  sps_wbuf #(.DEPTH(BLK_WORDS), .DW(DW)) u_wbuf (
    .clk(clk), .we(accept), .waddr(wcnt[WAW-1:0]), .wdata(wr_data),
    .raddr(vidx), .rdata(buf_rd)
  );

  assign set_prog = (state == ST_PRCHK) && !erased;
  assign set_ver  = (state == ST_VCHK) && mism;
  assign set_lock = (state == ST_SETUP) && lock_map[blk_q];

  sps_status #(.AW(AW)) u_status (
    .clk(clk), .rst_n(rst_n), .set_prog(set_prog), .set_ver(set_ver),
    .set_lock(set_lock), .clr(clr_cmd), .ver_addr({blk_q, vidx}),
    .prog_err(stat_prog_err), .ver_err(stat_verify_err),
    .lock_err(stat_lock_err), .fail_addr(fail_addr)
  );

  assign pulse_start   = (state == ST_PRCHK) && erased;
  assign arr_prog      = pulse_start;
  assign arr_wdata     = dat_q;
  assign arr_rd_en     = (state == ST_PRERD) || (state == ST_VRD);
  assign arr_addr      = (state == ST_VRD) ? {blk_q, vidx} : {blk_q, wcnt[WAW-1:0]};
  assign wr_ready      = (state == ST_PROG);
  assign stat_active   = (state != ST_IDLE);
  assign stat_busy     = stat_active && (state != ST_PROG);
  assign part_rd_grant = part_rd_req && (state == ST_IDLE);

  AST_LOCK_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    arr_prog |-> !lock_map[blk_q]); // R8
  AST_PROG_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    arr_prog |-> (wcnt < FULL)); // R4
  AST_PROG_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    arr_prog |=> !arr_prog); // R3
  AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !stat_busy && !pulse_run); // R3
  AST_WCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PULSE && pulse_done) |=> (wcnt == $past(wcnt) + CW'(1))); // R2
  AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    part_rd_grant |-> !stat_active); // R10
endmodule

// File: tb/stream_prog_seq_tb.sv
module stream_prog_seq_tb;
  localparam int NBLK = 4, BW = 8, DW = 8, PC = 3;
  localparam int AW = 5;
  localparam int NW = NBLK * BW;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic cmd_valid = 0; logic [2:0] cmd_op = 0; logic [1:0] cmd_blk = 0;
  logic [NBLK-1:0] lock_map = 4'b1000;
  logic wr_valid = 0, wr_ready; logic [DW-1:0] wr_data = 0;
  logic part_rd_req = 0, part_rd_grant;
  logic arr_prog, arr_rd_en; logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata, arr_rdata;
  logic stat_busy, stat_active, stat_prog_err, stat_verify_err, stat_lock_err;
  logic [AW-1:0] fail_addr;

  stream_prog_seq #(.NBLK(NBLK), .BLK_WORDS(BW), .DW(DW), .PULSE_CYC(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_blk(cmd_blk), .lock_map(lock_map), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .part_rd_req(part_rd_req),
    .part_rd_grant(part_rd_grant), .arr_prog(arr_prog), .arr_rd_en(arr_rd_en),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
    .stat_busy(stat_busy), .stat_active(stat_active),
    .stat_prog_err(stat_prog_err), .stat_verify_err(stat_verify_err),
    .stat_lock_err(stat_lock_err), .fail_addr(fail_addr)
  );

  // array model: erased = all ones, program clears bits, 1-cycle read
  logic [DW-1:0] mem [NW];
  logic do_erase = 0, do_poke = 0; logic [AW-1:0] poke_a = 0; logic [DW-1:0] poke_d = 0;
  int weak_a = -1;
  int n_prog = 0, n_rd = 0;
  always @(posedge clk) begin
    if (do_erase) for (int i = 0; i < NW; i++) mem[i] <= '1;
    else if (do_poke) mem[poke_a] <= poke_d;
    else if (arr_prog)
      mem[arr_addr] <= mem[arr_addr] & ((int'(arr_addr) == weak_a) ? (arr_wdata | 8'h01) : arr_wdata);
    if (arr_rd_en) arr_rdata <= mem[arr_addr];
    if (arr_prog) n_prog++;
    if (arr_rd_en) n_rd++;
  end

  int errors = 0, checks = 0;
  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dv(input int b, input int i);
    return DW'(b * 37 + i * 11 + 3);
  endfunction

  task automatic cmd(input logic [2:0] op, input logic [1:0] b);
    cmd_valid = 1; cmd_op = op; cmd_blk = b;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic erase_all();
    do_erase = 1; @(negedge clk); do_erase = 0;
  endtask

  task automatic poke(input int a, input logic [DW-1:0] d);
    do_poke = 1; poke_a = AW'(a); poke_d = d; @(negedge clk); do_poke = 0;
  endtask

  int low_cnt;
  task automatic send(input logic [DW-1:0] d, input bit with_end);
    wr_valid = 1; wr_data = d;
    while (!wr_ready) @(negedge clk);
    if (with_end) begin cmd_valid = 1; cmd_op = 3'd3; end
    @(negedge clk);
    wr_valid = 0; cmd_valid = 0;
    low_cnt = 0;
    while (!wr_ready && stat_active && stat_busy && low_cnt < 100) begin
      low_cnt++; @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 1000 && stat_active; k++) @(negedge clk);
  endtask

  task automatic full_session(input int b, input logic [DW-1:0] msk);
    cmd(3'd1, 2'(b)); @(negedge clk);
    for (int i = 0; i < BW; i++) send(dv(b, i) & msk, 0);
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p0, r0;
    for (int i = 0; i < NW; i++) mem[i] = '1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy", int'(stat_busy), 0);
    chk("R12 active", int'(stat_active), 0);
    chk("R12 errs", int'({stat_prog_err, stat_verify_err, stat_lock_err}), 0);
    chk("R12 ready", int'(wr_ready), 0);
    rst_n = 1; @(negedge clk);
    chk("R12 ready after reset", int'(wr_ready), 0);

    // R10 grant in idle
    part_rd_req = 1; @(negedge clk);
    chk("R10 grant idle", int'(part_rd_grant), 1);

    // R8 lock refusal on block 3
    p0 = n_prog;
    cmd(3'd1, 2'd3); @(negedge clk);
    chk("R8 lock err", int'(stat_lock_err), 1);
    chk("R8 back to idle", int'(stat_active), 0);
    chk("R8 no program", n_prog - p0, 0);
    cmd(3'd2, 2'd0);
    chk("R11 clear lock", int'(stat_lock_err), 0);

    // R1 R2 R3 R4 sweep over unlocked blocks
    for (int b = 0; b < NBLK - 1; b++) begin
      erase_all();
      p0 = n_prog; r0 = n_rd;
      cmd(3'd1, 2'(b));
      chk("R1 active after setup", int'(stat_active), 1);
      chk("R10 grant blocked", int'(part_rd_grant), 0);
      @(negedge clk);
      for (int i = 0; i < BW; i++) begin
        send(dv(b, i), 0);
        if (i < BW - 1) chk("R3 ready low cycles", low_cnt, PC + 2);
      end
      wait_idle();
      chk("R4 auto end", int'(stat_active), 0);
      chk("R4 no ready", int'(wr_ready), 0);
      chk("R3 one strobe per word", n_prog - p0, BW);
      chk("R1 pre-read plus verify reads", n_rd - r0, 2 * BW);
      chk("R1 no errors", int'({stat_prog_err, stat_verify_err}), 0);
      for (int a = 0; a < NW; a++)
        chk("R2 array word", int'(mem[a]), (a / BW == b) ? int'(dv(b, a % BW)) : 255);
    end

    // R5 end marker after 3 words
    erase_all(); p0 = n_prog;
    cmd(3'd1, 2'd2); @(negedge clk);
    for (int i = 0; i < 3; i++) send(dv(2, i), 0);
    cmd(3'd3, 2'd0); wait_idle();
    chk("R5 strobes", n_prog - p0, 3);
    for (int i = 0; i < BW; i++)
      chk("R5 word", int'(mem[2 * BW + i]), (i < 3) ? int'(dv(2, i)) : 255);

    // R5 end in same cycle as a beat
    erase_all(); p0 = n_prog;
    cmd(3'd1, 2'd1); @(negedge clk);
    send(dv(1, 0), 0); send(dv(1, 1), 0); send(dv(1, 2), 1);
    wait_idle();
    chk("R5 same-cycle strobes", n_prog - p0, 3);
    chk("R5 same-cycle beat", int'(mem[BW + 2]), int'(dv(1, 2)));
    chk("R5 next untouched", int'(mem[BW + 3]), 255);
    chk("R5 no errors", int'({stat_prog_err, stat_verify_err}), 0);

    // R9 suspend ignored
    erase_all(); p0 = n_prog;
    cmd(3'd1, 2'd0); @(negedge clk);
    for (int i = 0; i < BW; i++) begin
      send(dv(0, i), 0);
      if (i == 3) cmd(3'd4, 2'd0);
    end
    wait_idle();
    chk("R9 strobes", n_prog - p0, BW);
    chk("R9 last word", int'(mem[BW - 1]), int'(dv(0, BW - 1)));
    chk("R9 no errors", int'({stat_prog_err, stat_verify_err}), 0);

    // R6 verify mismatch on a weak word
    erase_all(); weak_a = BW + 5;
    full_session(1, 8'hFE);
    chk("R6 verify err", int'(stat_verify_err), 1);
    chk("R6 fail addr", int'(fail_addr), BW + 5);
    chk("R6 no prog err", int'(stat_prog_err), 0);
    weak_a = -1;

    // R11 sticky across a clean session, then clear
    erase_all(); full_session(2, 8'hFF);
    chk("R11 sticky verr", int'(stat_verify_err), 1);
    chk("R11 sticky addr", int'(fail_addr), BW + 5);
    cmd(3'd2, 2'd0);
    chk("R11 cleared", int'({stat_prog_err, stat_verify_err, stat_lock_err}), 0);

    // R7 non-erased target word
    erase_all(); poke(2, 8'h00); p0 = n_prog;
    full_session(0, 8'hFF);
    chk("R7 prog err", int'(stat_prog_err), 1);
    chk("R7 skipped strobe", n_prog - p0, BW - 1);
    chk("R7 next word advanced", int'(mem[3]), int'(dv(0, 3)));
    chk("R7 verify flags word", int'(fail_addr), 2);

    part_rd_req = 0; @(negedge clk);
    chk("R10 grant follows req", int'(part_rd_grant), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule